// File: doc/BRIEF.md
# Serial Audio Control Sequencer

This block sits between a register write port and the datapath of a serial audio (I2S-style) controller. Software writes a write-only command word. Each set bit of that word asks to turn the bit-clock generator, the transmitter or the receiver on or off, or it resets the whole block. The block turns those requests into run-enable levels for the transmit and receive shifters. It also drives an internal bit-clock and frame-select generator.

A status bit for a shifter does not follow the command directly. It follows the shifter's own acknowledge. A start stays pending until the shifter confirms it, and a stop stays in effect until the shifter confirms it has drained. Shifter starts also wait until the clock generator is running.

A second word holds the mode configuration. It accepts a new value only while nothing is active, so the serial outputs never change format mid-stream. A write that arrives while any function is active is dropped and recorded in a sticky error flag.

Top module: `sai_ctrl_seq`

## Requirements
- R1: After reset, every output is zero: clock on, bit clock, frame select, frame pulse, both run levels, both status bits, mode value and mode error.
- R2: A write to the command word (address 0x00) acts only through its bits at one. The bits are receiver on (bit 0), receiver off (bit 1), clock on (bit 2), clock off (bit 3), transmitter on (bit 4), transmitter off (bit 5) and software reset (bit 7). Bit 6 and bits 31:8 are ignored, and a word of all zeros changes nothing.
- R3: When an on bit and its matching off bit are both one in the same write, the off bit wins and the function does not start.
- R4: The clock-on state changes on the write itself. Within two cycles of the clock being off, the bit clock and frame select are low, and they stay low.
- R5: While the clock is on, the bit clock toggles every HALF_DIV cycles. A frame is FRAME_BITS bit-clock periods long. Frame select toggles twice per frame, and the frame pulse is high for one cycle per frame.
- R6: A shifter start makes its run level high from the cycle after the write, but only while the clock is on. A start issued with the clock off waits until the clock is enabled.
- R7: A status bit sets in the cycle after the shifter acknowledges while its run level is high. An acknowledge given while the run level is low is ignored.
- R8: An off command drops the run level at once. The status bit then clears in the cycle after the shifter acknowledges, or one cycle after stopping if the clock is off.
- R9: An off command issued while a start is still unacknowledged cancels the start, and the status bit stays zero.
- R10: Software reset returns all state to reset values in the cycle after the write, whatever other bits the write carries. This includes the status bits, the clock, the mode value and the error flag.
- R11: A write to the mode word (address 0x04) while clock, transmitter and receiver status are all zero stores the full 32-bit value.
- R12: A mode write while any of those is active is dropped and sets the mode error flag. The flag stays set until a software reset.
- R13: Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register byte address |
| wr_data_i | input | 32 | Register write data |
| tx_ack_i | input | 1 | Transmitter start/stop acknowledge |
| rx_ack_i | input | 1 | Receiver start/stop acknowledge |
| clk_on_o | output | 1 | Clock generation enabled |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame select (high in second half of frame) |
| frame_o | output | 1 | One-cycle pulse at each frame boundary |
| tx_run_o | output | 1 | Transmitter run enable |
| rx_run_o | output | 1 | Receiver run enable |
| tx_active_o | output | 1 | Transmitter status |
| rx_active_o | output | 1 | Receiver status |
| mode_o | output | 32 | Stored mode configuration |
| mode_err_o | output | 1 | Sticky flag: mode write dropped while active |

## Verification
The bench builds the block with HALF_DIV = 2 and FRAME_BITS = 4, so one frame lasts 16 cycles. A 64-cycle window then holds whole frames, and the bit-clock, frame-select and frame-pulse counts come out exactly. It sweeps all 64 combinations of the six on/off bits from a freshly reset state, with the reserved bits toggled alongside, and predicts each run level arithmetically. The small frame also keeps the handshake scenarios short: a start before the clock, a cancel, a stop with and without the clock, a reset mid-transfer and mode writes in both states.

// File: rtl/sai_seq_pkg.sv
package sai_seq_pkg;

  // command word bit positions (software-visible layout)
  localparam int unsigned CB_RX_ON  = 0;
  localparam int unsigned CB_RX_OFF = 1;
  localparam int unsigned CB_CK_ON  = 2;
  localparam int unsigned CB_CK_OFF = 3;
  localparam int unsigned CB_TX_ON  = 4;
  localparam int unsigned CB_TX_OFF = 5;
  localparam int unsigned CB_SRST   = 7;

  localparam int unsigned OFS_CMD  = 'h00;
  localparam int unsigned OFS_MODE = 'h04;

  localparam int unsigned NUM_FN = 2;  // index 0 = transmitter, 1 = receiver

  typedef enum logic [1:0] {
    FN_OFF   = 2'd0,
    FN_START = 2'd1,
    FN_ON    = 2'd2,
    FN_STOP  = 2'd3
  } fn_state_e;

  typedef struct packed {
    logic             srst;
    logic             ck_on;
    logic             ck_off;
    logic [NUM_FN-1:0] fn_on;
    logic [NUM_FN-1:0] fn_off;
  } cmd_t;

endpackage

// File: rtl/sai_cmd_decode.sv
module sai_cmd_decode
  import sai_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [6:0]        cmd_bits_i,  // {srst, bits 5:0}
  output cmd_t              cmd_o,
  output logic              mode_wr_o
);

  logic cmd_hit;

  always_comb begin
    cmd_hit   = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CMD));
    mode_wr_o = wr_en_i && (wr_addr_i == ADDR_W'(OFS_MODE));

    cmd_o.srst      = cmd_hit && cmd_bits_i[6];
    cmd_o.ck_on     = cmd_hit && cmd_bits_i[CB_CK_ON];
    cmd_o.ck_off    = cmd_hit && cmd_bits_i[CB_CK_OFF];
    cmd_o.fn_on[0]  = cmd_hit && cmd_bits_i[CB_TX_ON];
    cmd_o.fn_off[0] = cmd_hit && cmd_bits_i[CB_TX_OFF];
    cmd_o.fn_on[1]  = cmd_hit && cmd_bits_i[CB_RX_ON];
    cmd_o.fn_off[1] = cmd_hit && cmd_bits_i[CB_RX_OFF];
  end

endmodule

// File: rtl/sai_func_seq.sv
module sai_func_seq
  import sai_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic srst_i,
  input  logic clk_on_i,
  input  logic on_i,
  input  logic off_i,
  input  logic ack_i,
  output logic run_o,
  output logic stat_o
);

  fn_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FN_OFF:   if (on_i && !off_i) state_d = FN_START;
      FN_START: begin
        if (off_i)                  state_d = FN_OFF;
        else if (clk_on_i && ack_i) state_d = FN_ON;
      end
      FN_ON:    if (off_i) state_d = FN_STOP;
      FN_STOP:  if (ack_i || !clk_on_i) state_d = FN_OFF;
      default:  state_d = FN_OFF;
    endcase
    if (srst_i) state_d = FN_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FN_OFF;
    else        state_q <= state_d;
  end

  assign stat_o = (state_q == FN_ON) || (state_q == FN_STOP);
  assign run_o  = clk_on_i && ((state_q == FN_START) || (state_q == FN_ON));

  // R7
  stat_rise_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o) |-> $past(ack_i && run_o));

  // R8
  stat_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_o) |-> $past(srst_i || ack_i || !clk_on_i));

  // R3
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_i && off_i && !stat_o) |=> !run_o);

endmodule

// File: rtl/sai_clk_gen.sv
module sai_clk_gen #(
  parameter int unsigned HALF_DIV   = 4,
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic bclk_o,
  output logic fsync_o,
  output logic frame_o
);

  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_HALF  = IDX_W'(FRAME_BITS / 2);

  logic [DIV_W-1:0] div_q, div_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bclk_q, bclk_d;
  logic             frame_q, frame_d;

  always_comb begin
    div_d   = div_q;
    idx_d   = idx_q;
    bclk_d  = bclk_q;
    frame_d = 1'b0;
    if (!en_i) begin
      div_d  = '0;
      idx_d  = '0;
      bclk_d = 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_d  = '0;
      bclk_d = ~bclk_q;
      if (bclk_q) begin
        idx_d   = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        frame_d = (idx_q == IDX_LAST);
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      idx_q   <= '0;
      bclk_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      idx_q   <= idx_d;
      bclk_q  <= bclk_d;
      frame_q <= frame_d;
    end
  end

  assign bclk_o  = bclk_q;
  assign fsync_o = (idx_q >= IDX_HALF);
  assign frame_o = frame_q;

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!bclk_o && !fsync_o));

endmodule

// File: rtl/sai_ctrl_seq.sv
module sai_ctrl_seq
  import sai_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned HALF_DIV   = 4,
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              tx_ack_i,
  input  logic              rx_ack_i,
  output logic              clk_on_o,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic              frame_o,
  output logic              tx_run_o,
  output logic              rx_run_o,
  output logic              tx_active_o,
  output logic              rx_active_o,
  output logic [31:0]       mode_o,
  output logic              mode_err_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cmd_t cmd;
  logic mode_wr;

  sai_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .cmd_bits_i ({wr_data_i[CB_SRST], wr_data_i[5:0]}),
    .cmd_o      (cmd),
    .mode_wr_o  (mode_wr)
  );

  // clock enable state
  logic clk_en_q, clk_en_d;
  always_comb begin
    clk_en_d = clk_en_q;
    if (cmd.srst)        clk_en_d = 1'b0;
    else if (cmd.ck_off) clk_en_d = 1'b0;
    else if (cmd.ck_on)  clk_en_d = 1'b1;
  end

  // shifter sequencers
  logic [NUM_FN-1:0] fn_ack, fn_run, fn_stat;
  assign fn_ack = {rx_ack_i, tx_ack_i};

  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    sai_func_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .srst_i   (cmd.srst),
      .clk_on_i (clk_en_q),
      .on_i     (cmd.fn_on[g]),
      .off_i    (cmd.fn_off[g]),
      .ack_i    (fn_ack[g]),
      .run_o    (fn_run[g]),
      .stat_o   (fn_stat[g])
    );
  end

  // mode register with write guard
  logic        any_active;
  logic [31:0] mode_q, mode_d;
  logic        err_q, err_d;

  assign any_active = clk_en_q || (|fn_stat);

  always_comb begin
    mode_d = mode_q;
    err_d  = err_q;
    if (cmd.srst) begin
      mode_d = '0;
      err_d  = 1'b0;
    end else if (mode_wr) begin
      if (any_active) err_d  = 1'b1;
      else            mode_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      clk_en_q <= 1'b0;
      mode_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      clk_en_q <= clk_en_d;
      mode_q   <= mode_d;
      err_q    <= err_d;
    end
  end

  sai_clk_gen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_ckg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (clk_en_q),
    .bclk_o  (bclk_o),
    .fsync_o (fsync_o),
    .frame_o (frame_o)
  );

  assign clk_on_o    = clk_en_q;
  assign tx_run_o    = fn_run[0];
  assign rx_run_o    = fn_run[1];
  assign tx_active_o = fn_stat[0];
  assign rx_active_o = fn_stat[1];
  assign mode_o      = mode_q;
  assign mode_err_o  = err_q;

  // R12
  mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_wr && any_active) |=> ($stable(mode_o) && mode_err_o));

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd.srst |=> (!clk_on_o && !tx_active_o && !rx_active_o && mode_o == '0 && !mode_err_o));

endmodule

// File: tb/tb_sai_ctrl_seq.sv
module tb_sai_ctrl_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int HD = 2;
  localparam int FB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          tx_ack = 1'b0;
  logic          rx_ack = 1'b0;
  logic          clk_on, bclk, fsync, frame, tx_run, rx_run, tx_act, rx_act, merr;
  logic [31:0]   mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sai_ctrl_seq #(.ADDR_W(AW), .HALF_DIV(HD), .FRAME_BITS(FB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tx_ack_i(tx_ack), .rx_ack_i(rx_ack), .clk_on_o(clk_on), .bclk_o(bclk), .fsync_o(fsync),
    .frame_o(frame), .tx_run_o(tx_run), .rx_run_o(rx_run), .tx_active_o(tx_act),
    .rx_active_o(rx_act), .mode_o(mode), .mode_err_o(merr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack(input bit rx);
    @(negedge clk);
    if (rx) rx_ack = 1'b1; else tx_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_ack = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int nb, nf, nfr;
    logic pb, pf;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 outputs", {clk_on, bclk, fsync, frame, tx_run, rx_run, tx_act, rx_act, merr}, '0);
    chk("R1 mode", mode, '0);

    // R2 R3 R6 exhaustive sweep of six command bits, reserved bits toggled
    for (int i = 0; i < 64; i++) begin
      logic [31:0] d;
      logic ck, tx, rx;
      wr(8'h00, 32'h80);
      d = {((i % 2) ? 24'hFFFFFF : 24'h0), ((i % 2) ? 1'b0 : 1'b0), ((i % 2) ? 1'b1 : 1'b0), 6'(i)};
      wr(8'h00, d);
      ck = i[2] && !i[3];
      tx = ck && i[4] && !i[5];
      rx = ck && i[0] && !i[1];
      chk("R2 clk_on sweep", clk_on, ck);
      chk("R3 tx_run sweep", tx_run, tx);
      chk("R3 rx_run sweep", rx_run, rx);
      chk("R6 status sweep", {tx_act, rx_act}, 2'b00);
    end

    // R2 zero word has no effect
    wr(8'h00, 32'h80);
    wr(8'h00, 32'h04);
    wr(8'h00, 32'h0);
    chk("R2 zero write", clk_on, 1'b1);

    // R5 clock timing over 64 cycles (4 whole frames)
    idle(3);
    nb = 0; nf = 0; nfr = 0; pb = bclk; pf = fsync;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (bclk != pb) nb++;
      if (fsync != pf) nf++;
      if (frame) nfr++;
      pb = bclk; pf = fsync;
    end
    chk("R5 bclk toggles", nb, 64 / HD);
    chk("R5 fsync toggles", nf, 8);
    chk("R5 frame pulses", nfr, 4);

    // R4 clock off keeps outputs low
    wr(8'h00, 32'h08);
    chk("R4 clk_on off", clk_on, 1'b0);
    idle(1);
    nb = 0;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      if (bclk || fsync) nb++;
    end
    chk("R4 quiet", nb, 0);

    // R6 start before clock; R7 ack ignored without run
    wr(8'h00, 32'h80);
    wr(8'h00, 32'h10);
    chk("R6 tx waits clock", tx_run, 1'b0);
    ack(0);
    chk("R7 ack ignored", tx_act, 1'b0);
    wr(8'h00, 32'h04);
    chk("R6 tx run after clock", tx_run, 1'b1);
    chk("R7 status pending", tx_act, 1'b0);
    ack(0);
    chk("R7 tx status set", tx_act, 1'b1);

    // R12 mode write while active; R13 other address
    wr(8'h04, 32'h1234);
    chk("R12 mode kept", mode, 32'h0);
    chk("R12 error set", merr, 1'b1);
    wr(8'h08, 32'hFF);
    chk("R13 other addr", {clk_on, tx_run, tx_act, rx_run}, 4'b1110);

    // R8 stop with ack
    wr(8'h00, 32'h20);
    chk("R8 run drops", tx_run, 1'b0);
    chk("R8 status held", tx_act, 1'b1);
    ack(0);
    chk("R8 status clears", tx_act, 1'b0);
    chk("R12 error sticky", merr, 1'b1);

    // R8 stop with clock off at the same time
    wr(8'h00, 32'h01);
    ack(1);
    chk("R7 rx status set", rx_act, 1'b1);
    wr(8'h00, 32'h0A);
    chk("R8 rx stopping", {rx_run, rx_act}, 2'b01);
    idle(1);
    chk("R8 rx clears no clock", rx_act, 1'b0);

    // R9 cancel pending start
    wr(8'h00, 32'h14);
    chk("R9 start running", tx_run, 1'b1);
    wr(8'h00, 32'h20);
    ack(0);
    chk("R9 cancelled", {tx_run, tx_act}, 2'b00);

    // R10 reset during active transfer, other bits present
    wr(8'h00, 32'h11);
    ack(0);
    ack(1);
    wr(8'h04, 32'h55);
    chk("R10 both active", {tx_act, rx_act, merr}, 3'b111);
    wr(8'h00, 32'h95);
    chk("R10 cleared", {clk_on, tx_run, rx_run, tx_act, rx_act, merr}, '0);
    chk("R10 mode cleared", mode, '0);

    // R11 mode write idle
    wr(8'h04, 32'hA5A5_5A5A);
    chk("R11 mode stored", mode, 32'hA5A5_5A5A);
    chk("R11 no error", merr, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule